// File: doc/BRIEF.md
# Nested Priority Interrupt Entry and Return Sequencer

This block decides which interrupt a core services next, and carries out the entry and return bookkeeping for that interrupt in hardware. It has ten sources with fixed priority, and a lower index means a higher priority. Index 0 is the reset-class source and cannot be masked. Indices 0 to 6 are hardware request lines. Indices 7, 8 and 9 are three software levels, the lowest priorities, which software raises by setting their pending bits. Each source keeps a sticky pending bit, an enable bit and an in-service bit. A source is taken only when it is pending and enabled, and only when its priority is strictly higher than every source already in service.

Entry takes a fixed three-cycle path: the request is captured, then recognized, then branched to. On the branch cycle the block gives out the vector address of the source as a one-cycle pulse. It pushes the current PC onto a hardware PC stack, and it pushes the status word onto a status stack if the source is one of those that save status. It also marks the source as in service. A return command reverses these steps. The block gives out the top of the PC stack, and the status word when that source saved one, and it clears the pending and in-service bits of the innermost source.

Top module: `nest_irq_seq`

## Requirements
- R1: A hardware request line that is high before clock edge k sets its pending bit (latch_q bit = line index) at edge k. When the source is enabled, core_ready is high and nothing blocks it, vec_valid is high for exactly one cycle, after edge k+2, with vec_src equal to the source index.
- R2: vec_addr equals base + 8 × source index. The base is 0x20000 when ext_sel is 0 at the branch edge, and 0x40000 when ext_sel is 1.
- R3: When several eligible sources are pending at once, the one with the lowest index is taken. The others stay pending.
- R4: The enable register (reset value all zero) is written whole by mask_wr_en/mask_wr_data. A pending source whose enable bit is 0 is not taken until that bit is set; it is then taken two edges after the write edge. Source 0 is taken whatever its enable bit.
- R5: A source is taken only if its index is lower than that of every set bit of nest_q. On entry the source's bit in nest_q and in latch_q is set in the same edge that raises vec_valid.
- R6: Each entry pushes cur_pc. A return gives ret_valid for one cycle, one edge after rti is sampled, with ret_pc equal to the most recently pushed PC that has not yet been returned (last in, first out). vec_valid and ret_valid are never high together.
- R7: A return takes the lowest-index set bit of nest_q as ret_src, and clears that bit in both nest_q and latch_q. rti is acted on only when nest_q is non-zero and no entry is in progress. Otherwise it has no effect. A source held off by the returned one can be taken two edges after the return edge.
- R8: Sources 1 and 2 save status: their entry pushes st_in, and their return raises st_restore for one cycle, together with ret_valid, with st_out equal to the saved word. A return of any other source leaves st_restore low.
- R9: A cycle with sw_set_en high sets latch_q bit 7+i for each set bit i of sw_set. The software levels are then taken like any other source, at the third edge after the write.
- R10: No source is recognized while core_ready is low; its pending bit stays set. Once core_ready goes high, the source is taken two edges later.
- R11: Each stack holds 8 entries. A push onto a full stack is dropped and sets the stack's sticky overflow output (pc_ovf or st_ovf), which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 7 | Hardware request lines, sources 0 to 6 |
| sw_set_en | input | 1 | Set the software-level pending bits given by sw_set |
| sw_set | input | 3 | Software levels to raise, bit i is source 7+i |
| mask_wr_en | input | 1 | Write the enable register |
| mask_wr_data | input | 10 | New enable register value |
| core_ready | input | 1 | Core is executing or idle, so interrupts may be taken |
| ext_sel | input | 1 | Vector table base select: 0 internal, 1 external |
| cur_pc | input | 20 | PC to save on entry |
| st_in | input | 8 | Status word to save on entry |
| rti | input | 1 | Return-from-interrupt command |
| vec_valid | output | 1 | Branch pulse for an accepted interrupt |
| vec_src | output | 4 | Index of the source being entered |
| vec_addr | output | 20 | Vector address for the entered source |
| ret_valid | output | 1 | Return pulse |
| ret_src | output | 4 | Index of the source being returned from |
| ret_pc | output | 20 | PC to resume at |
| st_restore | output | 1 | Status word is being restored |
| st_out | output | 8 | Restored status word |
| latch_q | output | 10 | Pending bits |
| nest_q | output | 10 | In-service bits |
| pc_ovf | output | 1 | Sticky PC stack overflow |
| st_ovf | output | 1 | Sticky status stack overflow |

## Verification
An entry that is dropped or taken in the wrong order shows within two or three edges. vec_valid either fails to pulse at the third edge after the request, or it names the wrong vec_src, or it gives a vec_addr that is not base plus eight times the index. A corrupted stack pointer or a wrong in-service bit does not show until the next return. There, ret_pc, ret_src, st_restore or a latch_q bit that should have cleared differs one edge after rti. For this reason every entry in the tests is paired with a return, and the nested tests check the returns in reverse order.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int NUM_SRC    = 10;
  localparam int SW_LEVELS  = 3;
  localparam int HW_SRC     = NUM_SRC - SW_LEVELS;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int ADDR_W     = 20;
  localparam int ST_W       = 8;
  localparam int STK_DEPTH  = 8;
  localparam int VEC_STRIDE = 8;
  localparam logic [ADDR_W-1:0] BASE_INT = 20'h20000;
  localparam logic [ADDR_W-1:0] BASE_EXT = 20'h40000;
  // sources whose entry also saves the status word
  localparam logic [NUM_SRC-1:0] SAVE_MASK = 10'b00_0000_0110;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [IDX_W-1:0]   src_idx_t;
  typedef enum logic {SEQ_IDLE, SEQ_ENTER} seq_state_t;

  // lowest set index (highest priority); zero when none set
  function automatic src_idx_t first_set_f(src_vec_t v);
    src_idx_t r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = src_idx_t'(i);
    end
    return r;
  endfunction

  // sources strictly above the highest-priority in-service source
  function automatic src_vec_t above_f(src_vec_t nest);
    src_vec_t r = '0;
    logic seen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      seen = seen | nest[i];
      r[i] = ~seen;
    end
    return r;
  endfunction

  // bits 0..idx set
  function automatic src_vec_t upto_f(src_idx_t idx);
    src_vec_t r = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      r[i] = (src_idx_t'(i) <= idx);
    end
    return r;
  endfunction

  function automatic src_vec_t onehot_f(src_idx_t idx);
    return src_vec_t'(1) << idx;
  endfunction

  function automatic logic [ADDR_W-1:0] vec_addr_f(src_idx_t idx, logic ext);
    logic [ADDR_W-1:0] base = ext ? BASE_EXT : BASE_INT;
    return base + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);
  endfunction
endpackage

// File: rtl/isq_lifo.sv
module isq_lifo #(
  parameter int DEPTH = 8,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         ovf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          full;
  logic          empty;
  logic [AW-1:0] top_idx;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_idx = AW'(cnt - CW'(1));
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[AW'(cnt)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push && full) ovf <= 1'b1;
      if (push && !full)      cnt <= cnt + CW'(1);
      else if (pop && !empty) cnt <= cnt - CW'(1);
    end
  end

  AST_OVF_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R11
  AST_DEPTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(cnt)); // R11
endmodule

// File: rtl/isq_flags.sv
module isq_flags
  import isq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HW_SRC-1:0]    hw_req,
  input  logic                 sw_set_en,
  input  logic [SW_LEVELS-1:0] sw_set,
  input  logic                 mask_wr_en,
  input  src_vec_t             mask_wr_data,
  input  src_vec_t             ent_set,
  input  src_vec_t             ret_clr,
  output src_vec_t             latch,
  output src_vec_t             mask,
  output src_vec_t             nest
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic raise;
    logic pend_q;
    logic serv_q;
    if (g < HW_SRC) begin : g_hw
      assign raise = hw_req[g];
    end else begin : g_sw
      assign raise = sw_set_en & sw_set[g - HW_SRC];
    end

    // a return clears the bit even when a raise arrives in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pend_q <= 1'b0;
      else if (ret_clr[g])            pend_q <= 1'b0;
      else if (raise || ent_set[g])   pend_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          serv_q <= 1'b0;
      else if (ret_clr[g]) serv_q <= 1'b0;
      else if (ent_set[g]) serv_q <= 1'b1;
    end

    assign latch[g] = pend_q;
    assign nest[g]  = serv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask <= '0;
    else if (mask_wr_en) mask <= mask_wr_data;
  end

  AST_SW_RAISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set_en && sw_set[0] && !ret_clr[HW_SRC]) |=> latch[HW_SRC]); // R9
endmodule

// File: rtl/nest_irq_seq.sv
module nest_irq_seq
  import isq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HW_SRC-1:0]    irq_in,
  input  logic                 sw_set_en,
  input  logic [SW_LEVELS-1:0] sw_set,
  input  logic                 mask_wr_en,
  input  logic [NUM_SRC-1:0]   mask_wr_data,
  input  logic                 core_ready,
  input  logic                 ext_sel,
  input  logic [ADDR_W-1:0]    cur_pc,
  input  logic [ST_W-1:0]      st_in,
  input  logic                 rti,
  output logic                 vec_valid,
  output logic [IDX_W-1:0]     vec_src,
  output logic [ADDR_W-1:0]    vec_addr,
  output logic                 ret_valid,
  output logic [IDX_W-1:0]     ret_src,
  output logic [ADDR_W-1:0]    ret_pc,
  output logic                 st_restore,
  output logic [ST_W-1:0]      st_out,
  output logic [NUM_SRC-1:0]   latch_q,
  output logic [NUM_SRC-1:0]   nest_q,
  output logic                 pc_ovf,
  output logic                 st_ovf
);
  seq_state_t state_q;
  src_idx_t   sel_q;
  src_vec_t   mask_w;
  src_vec_t   eligible;
  src_idx_t   win_idx;
  src_idx_t   ret_idx;
  src_vec_t   ent_set;
  src_vec_t   ret_clr;
  logic       rec_go;
  logic       ent_go;
  logic       rti_go;
  logic       st_push;
  logic       st_pop;
  logic [ADDR_W-1:0] pc_top;
  logic [ST_W-1:0]   st_top;

  isq_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_req       (irq_in),
    .sw_set_en    (sw_set_en),
    .sw_set       (sw_set),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .ent_set      (ent_set),
    .ret_clr      (ret_clr),
    .latch        (latch_q),
    .mask         (mask_w),
    .nest         (nest_q)
  );

  // recognition: pending, enabled (source 0 always), above every in-service source
  assign eligible = latch_q & (mask_w | src_vec_t'(1)) & above_f(nest_q);
  assign win_idx  = first_set_f(eligible);
  assign ret_idx  = first_set_f(nest_q);

  assign rti_go  = rti && (state_q == SEQ_IDLE) && (|nest_q);
  assign rec_go  = (state_q == SEQ_IDLE) && core_ready && !rti_go && (|eligible);
  assign ent_go  = (state_q == SEQ_ENTER);
  assign ent_set = ent_go ? onehot_f(sel_q) : '0;
  assign ret_clr = rti_go ? onehot_f(ret_idx) : '0;
  assign st_push = ent_go && SAVE_MASK[sel_q];
  assign st_pop  = rti_go && SAVE_MASK[ret_idx];

  isq_lifo #(.DEPTH(STK_DEPTH), .W(ADDR_W)) u_pc_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ent_go),
    .pop   (rti_go),
    .din   (cur_pc),
    .top   (pc_top),
    .ovf   (pc_ovf)
  );

  isq_lifo #(.DEPTH(STK_DEPTH), .W(ST_W)) u_st_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (st_push),
    .pop   (st_pop),
    .din   (st_in),
    .top   (st_top),
    .ovf   (st_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      sel_q   <= '0;
    end else if (rec_go) begin
      state_q <= SEQ_ENTER;
      sel_q   <= win_idx;
    end else if (ent_go) begin
      state_q <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid  <= 1'b0;
      vec_src    <= '0;
      vec_addr   <= '0;
      ret_valid  <= 1'b0;
      ret_src    <= '0;
      ret_pc     <= '0;
      st_restore <= 1'b0;
      st_out     <= '0;
    end else begin
      vec_valid  <= ent_go;
      ret_valid  <= rti_go;
      st_restore <= st_pop;
      if (ent_go) begin
        vec_src  <= sel_q;
        vec_addr <= vec_addr_f(sel_q, ext_sel);
      end
      if (rti_go) begin
        ret_src <= ret_idx;
        ret_pc  <= pc_top;
      end
      if (st_pop) st_out <= st_top;
    end
  end

  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R1
  AST_VEC_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (latch_q[vec_src] && nest_q[vec_src])); // R5
  AST_NEST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (($past(nest_q) & upto_f(vec_src)) == '0)); // R5
  AST_NO_VEC_AND_RET: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && ret_valid)); // R6
  AST_RET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (!nest_q[ret_src] && !latch_q[ret_src])); // R7
  AST_ST_ONLY_SAVERS: assert property (@(posedge clk) disable iff (!rst_n)
    st_restore |-> (ret_valid && SAVE_MASK[ret_src])); // R8
  AST_ENTER_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ent_go |-> $past(core_ready)); // R10
  AST_VEC_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr >= BASE_INT)); // R2
endmodule

// File: tb/test_nest_irq_seq.sv
`timescale 1ns/1ps
module test_nest_irq_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_in = '0;
  logic        sw_set_en = 1'b0;
  logic [2:0]  sw_set = '0;
  logic        mask_wr_en = 1'b0;
  logic [9:0]  mask_wr_data = '0;
  logic        core_ready = 1'b1;
  logic        ext_sel = 1'b0;
  logic [19:0] cur_pc = '0;
  logic [7:0]  st_in = '0;
  logic        rti = 1'b0;
  logic        vec_valid;
  logic [3:0]  vec_src;
  logic [19:0] vec_addr;
  logic        ret_valid;
  logic [3:0]  ret_src;
  logic [19:0] ret_pc;
  logic        st_restore;
  logic [7:0]  st_out;
  logic [9:0]  latch_q;
  logic [9:0]  nest_q;
  logic        pc_ovf;
  logic        st_ovf;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  nest_irq_seq i_nest_irq_seq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sw_set_en(sw_set_en),
    .sw_set(sw_set), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .core_ready(core_ready), .ext_sel(ext_sel), .cur_pc(cur_pc),
    .st_in(st_in), .rti(rti), .vec_valid(vec_valid), .vec_src(vec_src),
    .vec_addr(vec_addr), .ret_valid(ret_valid), .ret_src(ret_src),
    .ret_pc(ret_pc), .st_restore(st_restore), .st_out(st_out),
    .latch_q(latch_q), .nest_q(nest_q), .pc_ovf(pc_ovf), .st_ovf(st_ovf)
  );

  function automatic longint exp_addr(int src, bit ext);
    return (ext ? 64'h40000 : 64'h20000) + src * 8;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_mask(input logic [9:0] v);
    mask_wr_en = 1'b1;
    mask_wr_data = v;
    step(1);
    mask_wr_en = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1;
    step(1);
    rti = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1);
      seen |= vec_valid;
    end
    chk(tag, "no entry while held off", seen, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R5", "reset nest_q", nest_q, 0);
    chk("R1", "reset latch_q", latch_q, 0);
    chk("R1", "reset vec_valid", vec_valid, 0);
    chk("R6", "reset ret_valid", ret_valid, 0);
    chk("R11", "reset pc_ovf", pc_ovf, 0);
  endtask

  task automatic t_basic();
    cur_pc = 20'h01234;
    irq_in = 7'b0001000;
    step(1);
    chk("R1", "pending after one edge", latch_q, 10'h008);
    chk("R1", "no vec at edge 1", vec_valid, 0);
    step(1);
    chk("R1", "no vec at edge 2", vec_valid, 0);
    step(1);
    chk("R1", "vec at edge 3", vec_valid, 1);
    chk("R1", "vec_src", vec_src, 3);
    chk("R2", "internal vec_addr", vec_addr, exp_addr(3, 0));
    chk("R5", "nest after entry", nest_q, 10'h008);
    irq_in = '0;
    step(1);
    chk("R1", "vec one cycle", vec_valid, 0);
    do_rti();
    chk("R6", "ret_valid", ret_valid, 1);
    chk("R6", "ret_pc", ret_pc, 20'h01234);
    chk("R7", "ret_src", ret_src, 3);
    chk("R7", "nest cleared", nest_q, 0);
    chk("R7", "latch cleared", latch_q, 0);
    chk("R8", "no restore for src3", st_restore, 0);
    step(1);
    chk("R6", "ret one cycle", ret_valid, 0);
  endtask

  task automatic t_priority();
    st_in = 8'h5A;
    cur_pc = 20'h00ABC;
    irq_in = 7'b0100100;
    step(3);
    chk("R3", "lowest index wins", vec_src, 2);
    chk("R3", "vec present", vec_valid, 1);
    irq_in = 7'b0100000;
    st_in = 8'h00;
    quiet(5, "R5");
    chk("R3", "loser stays pending", latch_q, 10'h024);
    do_rti();
    chk("R7", "ret_src 2", ret_src, 2);
    chk("R6", "ret_pc", ret_pc, 20'h00ABC);
    chk("R8", "restore for src2", st_restore, 1);
    chk("R8", "st_out", st_out, 8'h5A);
    step(1);
    chk("R7", "held source not yet", vec_valid, 0);
    step(1);
    chk("R7", "held source taken", vec_valid, 1);
    chk("R7", "held source index", vec_src, 5);
    irq_in = '0;
    do_rti();
    chk("R8", "no restore for src5", st_restore, 0);
    chk("R7", "ret_src 5", ret_src, 5);
  endtask

  task automatic t_mask();
    set_mask(10'h3EF);
    irq_in = 7'b0010000;
    step(1);
    chk("R4", "masked source latched", latch_q, 10'h010);
    quiet(5, "R4");
    set_mask(10'h3FF);
    step(1);
    chk("R4", "not yet after enable", vec_valid, 0);
    step(1);
    chk("R4", "taken after enable", vec_valid, 1);
    chk("R4", "enabled source index", vec_src, 4);
    irq_in = '0;
    do_rti();
    set_mask(10'h000);
    irq_in = 7'b0000001;
    step(3);
    chk("R4", "src0 ignores mask", vec_valid, 1);
    chk("R4", "src0 vec_addr", vec_addr, exp_addr(0, 0));
    irq_in = '0;
    do_rti();
    chk("R7", "src0 returned", ret_src, 0);
    set_mask(10'h3FF);
  endtask

  task automatic t_ext();
    ext_sel = 1'b1;
    irq_in = 7'b1000000;
    step(3);
    chk("R2", "external vec_addr", vec_addr, exp_addr(6, 1));
    irq_in = '0;
    ext_sel = 1'b0;
    do_rti();
  endtask

  task automatic t_sw();
    sw_set_en = 1'b1;
    sw_set = 3'b010;
    step(1);
    sw_set_en = 1'b0;
    sw_set = '0;
    chk("R9", "software bit pending", latch_q, 10'h100);
    step(2);
    chk("R9", "software vec", vec_valid, 1);
    chk("R9", "software src", vec_src, 8);
    chk("R9", "software addr", vec_addr, exp_addr(8, 0));
    do_rti();
    chk("R9", "software ret_src", ret_src, 8);
    chk("R9", "software cleared", latch_q, 0);
  endtask

  task automatic t_ready();
    core_ready = 1'b0;
    st_in = 8'h33;
    irq_in = 7'b0000010;
    step(1);
    chk("R10", "pending while not ready", latch_q, 10'h002);
    quiet(5, "R10");
    core_ready = 1'b1;
    step(1);
    chk("R10", "not yet after ready", vec_valid, 0);
    step(1);
    chk("R10", "taken after ready", vec_valid, 1);
    chk("R10", "ready src", vec_src, 1);
    irq_in = '0;
    st_in = 8'h00;
    do_rti();
    chk("R8", "restore for src1", st_restore, 1);
    chk("R8", "st_out src1", st_out, 8'h33);
  endtask

  task automatic t_lifo();
    cur_pc = 20'h11111;
    sw_set_en = 1'b1;
    sw_set = 3'b100;
    step(1);
    sw_set_en = 1'b0;
    sw_set = '0;
    step(2);
    chk("R6", "outer entry", vec_src, 9);
    cur_pc = 20'h22222;
    irq_in = 7'b0010000;
    step(3);
    chk("R6", "inner entry", vec_src, 4);
    chk("R5", "both in service", nest_q, 10'h210);
    irq_in = '0;
    do_rti();
    chk("R6", "inner ret_pc", ret_pc, 20'h22222);
    chk("R7", "inner ret_src", ret_src, 4);
    do_rti();
    chk("R6", "outer ret_pc", ret_pc, 20'h11111);
    chk("R7", "outer ret_src", ret_src, 9);
  endtask

  task automatic t_rti_empty();
    do_rti();
    chk("R7", "rti with none in service", ret_valid, 0);
    chk("R7", "latch untouched", latch_q, 0);
    chk("R7", "nest untouched", nest_q, 0);
  endtask

  task automatic t_ovf();
    for (int k = 9; k >= 0; k--) begin
      cur_pc = 20'(32'h100 + k);
      if (k >= 7) begin
        sw_set_en = 1'b1;
        sw_set = 3'(1 << (k - 7));
      end else begin
        irq_in = 7'(1 << k);
      end
      step(1);
      sw_set_en = 1'b0;
      sw_set = '0;
      irq_in = '0;
      step(2);
      chk("R11", "nested entry index", vec_src, k);
      if (k == 2) chk("R11", "no overflow at eight", pc_ovf, 0);
      if (k == 1) chk("R11", "overflow at ninth", pc_ovf, 1);
    end
    chk("R11", "status stack not overflowed", st_ovf, 0);
    chk("R11", "overflow sticky", pc_ovf, 1);
    do_rti();
    chk("R11", "dropped pushes", ret_pc, 20'h00102);
    chk("R7", "innermost returned", ret_src, 0);
  endtask

  initial begin
    t_reset();
    set_mask(10'h3FF);
    t_basic();
    t_priority();
    t_mask();
    t_ext();
    t_sw();
    t_ready();
    t_lifo();
    t_rti_empty();
    t_ovf();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule